// File: doc/BRIEF.md
# Byte-wide SPI Master with Register Host Port

This block is an SPI master driven through a small byte-wide register port. The host configures clock polarity, clock phase and a serial clock divider. It drives four chip-select lines directly from a software register. It starts a transfer by writing a byte to the data offset. Each such write shifts eight bits out on MOSI, most significant bit first, and captures eight bits from MISO at the same time. The captured byte lands in a holding register behind the shifter, so the next transfer can run before the host has read the previous result.

A mode-fault input lets another master claim the bus. When it is pulled low while the core is enabled as master, the running transfer stops and the core leaves master mode. The core then latches an error flag and raises its interrupt. The interrupt can also report a completed transfer.

The serial engine is a three-state machine. `ST_IDLE` holds SCLK at the polarity level and waits for a start. Start moves it to `ST_RUN`. `ST_RUN` counts half-periods and toggles SCLK sixteen times. After the sixteenth edge it moves to `ST_COMMIT`. `ST_COMMIT` lasts one cycle: the received byte is handed over and the engine returns to `ST_IDLE`. A mode fault forces `ST_IDLE` from any state.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the registers read as follows: offset 0 (control) reads 0x51, offset 3 (extended control) reads 0x00, offset 5 (soft select) reads 0x00 and offset 1 (status) reads 0x05. All `cs_n` lines are high, and `sclk` and `irq` are low.
- R2: The register offsets are fixed: control 0, status 1, data 2, extended control 3, soft select 5. Offsets 4 and 6 are reserved: writes to them change nothing and they read 0x00. Extended control reads back what was written.
- R3: The divider code is {ext[1:0], ctrl[1:0]}, with the control bits forming the low half. The code sets the SCLK period in system clocks: 0→2, 1→4, 2→16, 3→32, 4→8, 5→64, 6→128, 7→256, 8→512, 9→1024, 10→2048, 11→4096. Codes 12 to 15 also give 4096. Each SCLK half-period lasts exactly half the period.
- R4: Control bit 3 sets the level SCLK rests at between transfers. Control bit 2 = 0 samples on the first edge of each bit and shifts on the second edge; bit 2 = 1 does the reverse. Bits go out and come in most significant first.
- R5: A write to offset 2, with the core enabled and in master mode, starts one 8-bit full-duplex exchange of 16 SCLK edges. The byte captured from MISO is then read at offset 2.
- R6: Status bit 2 (transmit empty) reads 0 from the cycle after the data write until the exchange ends. Status bit 7 (done) sets one system clock after the last SCLK edge. Writing 1 to bit 7 clears it.
- R7: Status bit 0 (receive empty) clears when a received byte lands and sets when offset 2 is read. The held byte stays readable until the next exchange completes.
- R8: A data write while an exchange is running sets status bit 6 (collision). That write is dropped and the running exchange is not disturbed. Writing 1 to bit 6 clears it.
- R9: In the soft-select register, bit n (n = 0..3) hands line n to software and bit n+4 gives its level. `cs_n[n]` equals bit n+4 when bit n is 1 and is high otherwise.
- R10: With control bit 6 (enable) = 0, or control bit 4 (master) = 0, a data write starts nothing: transmit empty stays 1 and SCLK does not move.
- R11: `fault_n` low while enable and master are both set does four things in the next cycle: status bit 4 (mode fault) sets, control bit 4 clears, any exchange aborts and SCLK returns to the polarity level. Writing 1 to status bit 4 clears the flag.
- R12: `irq` is the mode-fault flag OR (control bit 7 AND the done flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at offset 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select lines |
| fault_n | input | 1 | Mode-fault request, active low, synchronous |
| irq | output | 1 | Interrupt request |

## Verification
A data write registers on the clock edge where it is presented, and the engine enters `ST_RUN` on that same edge. Status bit 2 therefore reads 0 on the next register read. The first SCLK edge follows one half-period later, and the done flag and received byte appear one clock after the sixteenth edge. The bench drives at falling clock edges and samples combinational read data just after them. For completion it polls the done bit rather than assuming a count. It times SCLK edges in system clocks and expects exactly half the divisor between the first two. A mode fault and a soft-select write each take effect on the next clock edge, so their results are read on the following cycle.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int unsigned REG_W = 8;

    // register offsets
    localparam logic [2:0] OFF_CTRL   = 3'd0;
    localparam logic [2:0] OFF_STAT   = 3'd1;
    localparam logic [2:0] OFF_DATA   = 3'd2;
    localparam logic [2:0] OFF_EXT    = 3'd3;
    localparam logic [2:0] OFF_PARAM  = 3'd4;
    localparam logic [2:0] OFF_SOFTCS = 3'd5;
    localparam logic [2:0] OFF_TIMING = 3'd6;

    // control bit positions
    localparam int unsigned CTRL_IE   = 7;
    localparam int unsigned CTRL_EN   = 6;
    localparam int unsigned CTRL_MSTR = 4;
    localparam int unsigned CTRL_CPOL = 3;
    localparam int unsigned CTRL_CPHA = 2;

    // status bit positions
    localparam int unsigned STAT_DONE = 7;
    localparam int unsigned STAT_WCOL = 6;
    localparam int unsigned STAT_MODF = 4;
    localparam int unsigned STAT_TXE  = 2;
    localparam int unsigned STAT_RXE  = 0;

    localparam logic [REG_W-1:0] CTRL_RST = 8'h51;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_COMMIT = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/spi_div_decode.sv
// Maps the 4-bit divider code to an SCLK half-period in system clocks.
module spi_div_decode #(
    parameter int CODE_W = 4,
    parameter int HALF_W = 12
) (
    input  logic [CODE_W-1:0] code,
    output logic [HALF_W-1:0] half_period
);
    localparam logic [CODE_W-1:0] CLAMP_CODE = CODE_W'(11);

    logic [CODE_W-1:0] log2_div;

    always_comb begin
        case (code)
            CODE_W'(0): log2_div = CODE_W'(1);
            CODE_W'(1): log2_div = CODE_W'(2);
            CODE_W'(2): log2_div = CODE_W'(4);
            CODE_W'(3): log2_div = CODE_W'(5);
            CODE_W'(4): log2_div = CODE_W'(3);
            default:    log2_div = (code >= CLAMP_CODE) ? CODE_W'(HALF_W)
                                                        : code + CODE_W'(1);
        endcase
        half_period = HALF_W'(1) << (log2_div - CODE_W'(1));
    end
endmodule

// File: rtl/spi_bit_engine.sv
// Serial engine: edge generation, shifting and sampling for one byte.
module spi_bit_engine
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [HALF_W-1:0] half_period,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int EDGE_W = $clog2(2 * DATA_W);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);

    xfer_state_t       state_q;
    logic [HALF_W-1:0] hcnt_q;
    logic [EDGE_W-1:0] edge_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              sclk_q;

    logic tick;
    logic sample_edge;
    logic first_edge;

    assign tick        = (hcnt_q == half_period - HALF_W'(1));
    assign sample_edge = (edge_q[0] == cpha);
    assign first_edge  = (edge_q == '0);

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hcnt_q  <= '0;
            edge_q  <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            sclk_q  <= 1'b0;
        end else if (abort) begin
            state_q <= ST_IDLE;
            hcnt_q  <= '0;
            sclk_q  <= cpol;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sclk_q <= cpol;
                    if (start) begin
                        tx_sh_q <= tx_byte;
                        rx_sh_q <= '0;
                        hcnt_q  <= '0;
                        edge_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        hcnt_q <= '0;
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_q + EDGE_W'(1);
                        if (sample_edge) begin
                            rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
                        end else if (!(cpha && first_edge)) begin
                            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                        end
                        if (edge_q == LAST_EDGE) begin
                            state_q <= ST_COMMIT;
                        end
                    end else begin
                        hcnt_q <= hcnt_q + HALF_W'(1);
                    end
                end
                ST_COMMIT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_COMMIT);
        sclk    = sclk_q;
        mosi    = tx_sh_q[DATA_W-1];
        rx_byte = rx_sh_q;
    end
endmodule

// File: rtl/spi_rx_hold.sv
// Holding stage behind the shifter: keeps the last received byte.
module spi_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              pop,
    output logic [DATA_W-1:0] hold_data,
    output logic              full
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            full      <= 1'b0;
        end else if (load) begin
            hold_data <= load_data;
            full      <= 1'b1;
        end else if (pop) begin
            full      <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_host_ctrl.sv
// Register-mapped SPI master: register file, status flags, soft selects.
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int NUM_CS = 4,   // soft-select register holds 2*NUM_CS bits, at most 8
    parameter int CODE_W = 4,
    parameter int HALF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    input  logic              fault_n,
    output logic              irq
);
    localparam int SEL_W  = 2 * NUM_CS;
    localparam int HALF_C = CODE_W / 2;

    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] ext_q;
    logic [SEL_W-1:0] softcs_q;
    logic             done_q;
    logic             wcol_q;
    logic             modf_q;

    logic              eng_busy;
    logic              eng_done;
    logic [REG_W-1:0]  eng_rx;
    logic [REG_W-1:0]  rx_hold;
    logic              rx_full;
    logic [HALF_W-1:0] half_period;
    logic [CODE_W-1:0] div_code;
    logic [REG_W-1:0]  status_w;

    logic wr_ctrl, wr_stat, wr_data, wr_ext, wr_sel, rd_data;
    logic fault_hit, start;

    assign wr_ctrl = reg_wr && (reg_addr == OFF_CTRL);
    assign wr_stat = reg_wr && (reg_addr == OFF_STAT);
    assign wr_data = reg_wr && (reg_addr == OFF_DATA);
    assign wr_ext  = reg_wr && (reg_addr == OFF_EXT);
    assign wr_sel  = reg_wr && (reg_addr == OFF_SOFTCS);
    assign rd_data = reg_rd && (reg_addr == OFF_DATA);

    assign fault_hit = ctrl_q[CTRL_EN] && ctrl_q[CTRL_MSTR] && !fault_n;
    assign start     = wr_data && ctrl_q[CTRL_EN] && ctrl_q[CTRL_MSTR]
                       && !eng_busy && !fault_hit;
    assign div_code  = {ext_q[HALF_C-1:0], ctrl_q[HALF_C-1:0]};

    spi_div_decode #(.CODE_W(CODE_W), .HALF_W(HALF_W)) div_i (
        .code        (div_code),
        .half_period (half_period)
    );

    spi_bit_engine #(.DATA_W(REG_W), .HALF_W(HALF_W)) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .abort       (fault_hit),
        .cpol        (ctrl_q[CTRL_CPOL]),
        .cpha        (ctrl_q[CTRL_CPHA]),
        .tx_byte     (reg_wdata),
        .half_period (half_period),
        .miso        (miso),
        .busy        (eng_busy),
        .done        (eng_done),
        .sclk        (sclk),
        .mosi        (mosi),
        .rx_byte     (eng_rx)
    );

    spi_rx_hold #(.DATA_W(REG_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (eng_done),
        .load_data (eng_rx),
        .pop       (rd_data),
        .hold_data (rx_hold),
        .full      (rx_full)
    );

    // configuration registers and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RST;
            ext_q    <= '0;
            softcs_q <= '0;
            done_q   <= 1'b0;
            wcol_q   <= 1'b0;
            modf_q   <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata;
            if (fault_hit) ctrl_q[CTRL_MSTR] <= 1'b0;
            if (wr_ext) ext_q <= reg_wdata;
            if (wr_sel) softcs_q <= reg_wdata[SEL_W-1:0];

            if (eng_done) done_q <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_DONE]) done_q <= 1'b0;

            if (wr_data && eng_busy) wcol_q <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_WCOL]) wcol_q <= 1'b0;

            if (fault_hit) modf_q <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_MODF]) modf_q <= 1'b0;
        end
    end

    always_comb begin
        status_w            = '0;
        status_w[STAT_DONE] = done_q;
        status_w[STAT_WCOL] = wcol_q;
        status_w[STAT_MODF] = modf_q;
        status_w[STAT_TXE]  = !eng_busy;
        status_w[STAT_RXE]  = !rx_full;
    end

    always_comb begin
        case (reg_addr)
            OFF_CTRL:   reg_rdata = ctrl_q;
            OFF_STAT:   reg_rdata = status_w;
            OFF_DATA:   reg_rdata = rx_hold;
            OFF_EXT:    reg_rdata = ext_q;
            OFF_SOFTCS: reg_rdata = REG_W'(softcs_q);
            default:    reg_rdata = '0;
        endcase
    end

    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
            assign cs_n[g] = softcs_q[g] ? softcs_q[g + NUM_CS] : 1'b1;
        end
    endgenerate

    assign irq = modf_q || (ctrl_q[CTRL_IE] && done_q);
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       fault_n,
    input logic       irq,
    input logic       sclk,
    input logic       busy,
    input logic       done,
    input logic [7:0] ctrl,
    input logic [7:0] status
);
    // R8: a data write during an exchange raises the collision flag
    a_r8_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2 && busy) |=> status[6]);

    // R11: a mode fault leaves master mode, stops the exchange, sets the flag
    a_r11_fault_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[6] && ctrl[4] && !fault_n) |=> (status[4] && !ctrl[4] && !busy));

    // R12: the mode-fault flag always drives the interrupt
    a_r12_modf_irq: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] |-> irq);

    // R6: the hand-over lasts a single cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a completed exchange leaves a byte in the holding register
    a_r7_rx_lands: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !status[0]);

    // R4: SCLK rests at the polarity level while idle
    a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(ctrl[3])) |-> (sclk == ctrl[3]));

    // R10: a disabled core never starts
    a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[6] && !busy) |=> !busy);
endmodule

bind spi_host_ctrl spi_host_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .fault_n  (fault_n),
    .irq      (irq),
    .sclk     (sclk),
    .busy     (eng_busy),
    .done     (eng_done),
    .ctrl     (ctrl_q),
    .status   (status_w)
);

// File: tb/spi_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_host_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sclk, mosi;
    logic       miso = 1'b0;
    logic [3:0] cs_n;
    logic       fault_n = 1'b1;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    spi_host_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .fault_n(fault_n), .irq(irq)
    );

    // cycle counter and SCLK edge monitor
    int cyc = 0;
    int edge_n = 0;
    int t1 = 0;
    int t2 = 0;
    always @(posedge clk) cyc++;
    always @(sclk) if (rst_n) begin
        edge_n++;
        if (edge_n == 1) t1 = cyc;
        else if (edge_n == 2) t2 = cyc;
    end

    // slave model
    bit       slave_on = 0;
    bit       s_cpol = 0;
    bit       s_cpha = 0;
    logic [7:0] s_out = '0;
    logic [7:0] s_in = '0;
    always @(sclk) if (slave_on) begin
        if (sclk != s_cpol) begin          // leading edge
            if (s_cpha) begin miso = s_out[7]; s_out = s_out << 1; end
            else s_in = {s_in[6:0], mosi};
        end else begin                     // trailing edge
            if (s_cpha) s_in = {s_in[6:0], mosi};
            else begin s_out = s_out << 1; miso = s_out[7]; end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] ctrl, input logic [7:0] ext);
        s_cpol = ctrl[3];
        s_cpha = ctrl[2];
        wr(3'd0, ctrl);
        wr(3'd3, ext);
    endtask

    task automatic wait_done();
        logic [7:0] st;
        for (int i = 0; i < 40000; i++) begin
            rd(3'd1, st);
            if (st[7]) break;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] resp,
                        output logic [7:0] got);
        s_out = resp; s_in = '0;
        if (!s_cpha) miso = resp[7];
        slave_on = 1;
        edge_n = 0;
        wr(3'd2, tx);
        wait_done();
        slave_on = 0;
        wr(3'd1, 8'h80);
        rd(3'd2, got);
    endtask

    function automatic int exp_div(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 16;
            3: return 32;
            4: return 8;
            default: return (code >= 11) ? 4096 : (1 << (code + 1));
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] got;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(3'd0, v); check("R1 ctrl", v, 8'h51);
        rd(3'd1, v); check("R1 status", v, 8'h05);
        rd(3'd3, v); check("R1 ext", v, 8'h00);
        rd(3'd5, v); check("R1 softcs", v, 8'h00);
        check("R1 cs_n", cs_n, 4'hF);
        check("R1 sclk", sclk, 0);
        check("R1 irq", irq, 0);

        // R2: reserved offsets and extended readback
        wr(3'd4, 8'hFF); rd(3'd4, v); check("R2 offset4", v, 0);
        wr(3'd6, 8'hFF); rd(3'd6, v); check("R2 offset6", v, 0);
        wr(3'd3, 8'hA6); rd(3'd3, v); check("R2 ext", v, 8'hA6);
        wr(3'd3, 8'h00);
        rd(3'd0, v); check("R2 ctrl untouched", v, 8'h51);

        // R9: every soft-select value
        for (int s = 0; s < 256; s++) begin
            logic [3:0] e;
            wr(3'd5, s[7:0]);
            for (int n = 0; n < 4; n++) e[n] = s[n] ? s[n+4] : 1'b1;
            check("R9 cs_n", cs_n, e);
        end

        // R4 R5: full byte sweep in all four modes, divisor 4
        for (int m = 0; m < 4; m++) begin
            set_mode(8'h51 | 8'(m << 2), 8'h00);
            for (int b = 0; b < 256; b++) begin
                logic [7:0] resp;
                resp = {b[0], b[7:1]} ^ 8'h96 ^ 8'(m);
                xfer(b[7:0], resp, got);
                check("R5 rx byte", got, resp);
                check("R4 slave got", s_in, b);
                check("R4 sclk idle", sclk, m >> 1);
            end
        end
        check("R12 no irq without enable", irq, 0);

        // R6 R7: flags around one exchange
        set_mode(8'h51, 8'h00);
        s_out = 8'h3C; s_in = '0; miso = 1'b0; slave_on = 1;
        wr(3'd2, 8'hC3);
        rd(3'd1, v); check("R6 tx empty low while busy", v[2], 0);
        wait_done();
        slave_on = 0;
        rd(3'd1, v); check("R6 done set", v[7], 1);
        check("R7 rx not empty", v[0], 0);
        wr(3'd1, 8'h80);
        rd(3'd1, v); check("R6 done cleared", v[7], 0);
        check("R6 tx empty after", v[2], 1);
        rd(3'd2, got); check("R7 first read", got, 8'h3C);
        rd(3'd1, v); check("R7 rx empty after read", v[0], 1);
        rd(3'd2, got); check("R7 held byte", got, 8'h3C);

        // R8: collision
        set_mode(8'h52, 8'h00);
        s_out = 8'h81; s_in = '0; miso = 1'b1; slave_on = 1;
        wr(3'd2, 8'h5A);
        wr(3'd2, 8'hFF);
        rd(3'd1, v); check("R8 collision flag", v[6], 1);
        wait_done();
        slave_on = 0;
        rd(3'd2, got); check("R8 rx intact", got, 8'h81);
        check("R8 slave saw first byte", s_in, 8'h5A);
        wr(3'd1, 8'hC0);
        rd(3'd1, v); check("R8 collision cleared", v[6], 0);

        // R10: disabled core, then slave mode
        wr(3'd0, 8'h11);
        edge_n = 0;
        wr(3'd2, 8'hAA);
        repeat (20) @(negedge clk);
        rd(3'd1, v);
        check("R10 disabled tx empty", v[2], 1);
        check("R10 disabled no done", v[7], 0);
        check("R10 disabled no edges", edge_n, 0);
        wr(3'd0, 8'h41);
        edge_n = 0;
        wr(3'd2, 8'hAA);
        repeat (20) @(negedge clk);
        rd(3'd1, v);
        check("R10 slave tx empty", v[2], 1);
        check("R10 slave no edges", edge_n, 0);

        // R12: completion interrupt
        set_mode(8'hD1, 8'h00);
        xfer(8'h11, 8'h22, got);
        wr(3'd0, 8'hD1);
        s_out = 8'h00; miso = 1'b0; slave_on = 1;
        wr(3'd2, 8'h00);
        wait_done();
        slave_on = 0;
        check("R12 irq on done", irq, 1);
        wr(3'd1, 8'h80);
        check("R12 irq cleared", irq, 0);

        // R11: mode fault
        set_mode(8'h52, 8'h00);
        wr(3'd2, 8'hF0);
        repeat (10) @(negedge clk);
        fault_n = 1'b0;
        @(negedge clk);
        fault_n = 1'b1;
        rd(3'd1, v);
        check("R11 fault flag", v[4], 1);
        check("R11 aborted", v[2], 1);
        check("R11 sclk idle", sclk, 0);
        check("R12 irq on fault", irq, 1);
        rd(3'd0, v); check("R11 master cleared", v, 8'h42);
        wr(3'd1, 8'h10);
        rd(3'd1, v); check("R11 fault cleared", v[4], 0);
        check("R12 irq released", irq, 0);

        // R3: divider codes 0..12
        for (int c = 0; c <= 12; c++) begin
            set_mode(8'h50 | 8'(c & 3), 8'(c >> 2));
            xfer(8'hA5, 8'h5A, got);
            check("R3 half period", t2 - t1, exp_div(c) / 2);
            check("R3 edge count", edge_n, 16);
        end

        finish_run();
    end
endmodule